// File: doc/BRIEF.md
# SPI Word Packer and Unpacker

This block connects a 32-bit FIFO register port to the word interface of a serial shift engine. On the transmit side, software writes FIFO words. The unpacker then hands the engine one SPI word at a time, taken from successive bit slots of the head FIFO word. On the receive side, words arriving from the engine are gathered into FIFO words. Software reads those FIFO words together with an occupancy count, a flag marking the end of the transfer, and the number of valid bytes in the final word.

The word length is programmable from 4 to 32 bits. When the length divides the FIFO width evenly, several SPI words share one FIFO word. Otherwise each FIFO word carries exactly one SPI word. A bit-order option mirrors every word inside its own field, so the engine can always shift the most significant bit first. Both FIFOs are plain synchronous queues whose depth is a parameter. Pushing into a full FIFO sets a sticky error flag, and so does popping an empty one.

Top module: `spi_pack_top`

## Requirements
- R1: When 32 is a multiple of the word length L, each FIFO word holds 32/L words. The first word sits in bits [L-1:0] and word k sits at bit offset k*L. Transmit hands them out in slot order and frees the FIFO word after the last slot. Receive completes a FIFO word after 32/L accepted words.
- R2: When L does not divide 32, each FIFO word holds one word in bits [L-1:0]. On receive, the bits above L are zero, whatever the engine drove there.
- R3: With `cfgLsbFirst` = 1, every word is mirrored inside its L-bit field in both directions (field bit i maps to bit L-1-i). With `cfgLsbFirst` = 0, words pass through unchanged.
- R4: An `engRxEnd` pulse flushes a partially filled receive word into the FIFO. A word accepted in the same cycle is included. `rxLastBytes` then equals ceil(filled bits / 8) modulo 4, where 0 means all four bytes are valid.
- R5: `rxLast` rises the cycle after `engRxEnd`. It stays high until a pop leaves the receive FIFO empty.
- R6: `rxWordCount` equals the receive FIFO occupancy. `engRxRoom` is high exactly while that occupancy is below DEPTH-2.
- R7: An `engTxEnd` given together with a take, or while the head FIFO word is partly consumed, discards the unused slots of that head word.
- R8: A push into a full FIFO is dropped and sets `errWr` until reset. A pop from an empty FIFO changes nothing and sets `errRd` until reset.
- R9: After reset, both FIFOs are empty, `engTxValid`, `rxLast` and both error flags are 0, and `engRxRoom` is 1.
- R10: `engTxValid` is high exactly while the transmit FIFO holds at least one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWordLen | input | 6 | Word length in bits, 4 to 32 |
| cfgLsbFirst | input | 1 | Mirror each word inside its field |
| hostTxPush | input | 1 | Write one FIFO word into the transmit FIFO |
| hostTxData | input | 32 | Transmit FIFO word |
| engTxValid | output | 1 | A transmit word is available |
| engTxWord | output | 32 | Current transmit word, right-aligned |
| engTxTake | input | 1 | Engine consumes the current word |
| engTxEnd | input | 1 | Transfer ends; drop the rest of the head word |
| engRxValid | input | 1 | Engine delivers a received word |
| engRxWord | input | 32 | Received word, right-aligned |
| engRxEnd | input | 1 | Receive transfer ends; flush the partial word |
| engRxRoom | output | 1 | Receive FIFO below its ready level |
| hostRxPop | input | 1 | Remove the head receive FIFO word |
| hostRxData | output | 32 | Head receive FIFO word |
| rxWordCount | output | 4 | Receive FIFO occupancy |
| rxLast | output | 1 | The final word of a transfer is queued |
| rxLastBytes | output | 2 | Valid bytes in the final word, 0 means four |
| errWr | output | 1 | Sticky: push into a full FIFO |
| errRd | output | 1 | Sticky: pop from an empty FIFO |

## Verification
A transmit slot index that drifts out of step shows up on the very next take: the engine receives a field from the wrong offset, or the head word is freed too early and the following word appears a slot ahead. A wrong receive fill count shows up when the FIFO word completes, one word too early or too late, and the count and data read by the host are visibly shifted. A flush error appears in the cycle after the end pulse, through `rxLastBytes`, `rxLast` or an occupancy that is off by one.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;
  localparam int unsigned FIFO_W = 32;
  localparam int unsigned LEN_W  = $clog2(FIFO_W) + 1;

  // strobes and offsets handed from control to datapath
  typedef struct packed {
    logic             rxMerge;
    logic             rxClear;
    logic [LEN_W-1:0] rxShift;
    logic [LEN_W-1:0] txShift;
  } ctrl_t;

  // right-aligned word of length len, mirrored when lsbFirst is set
  function automatic logic [FIFO_W-1:0] orientWord(input logic [FIFO_W-1:0] raw,
                                                   input logic [LEN_W-1:0] len,
                                                   input logic lsbFirst);
    logic [FIFO_W-1:0] mirrored;
    logic [FIFO_W-1:0] mask;
    for (int i = 0; i < FIFO_W; i++) mirrored[i] = raw[FIFO_W-1-i];
    mask = (len >= LEN_W'(FIFO_W)) ? '1 : ((FIFO_W'(1) << len) - FIFO_W'(1));
    if (lsbFirst) return mirrored >> (LEN_W'(FIFO_W) - len);
    return raw & mask;
  endfunction

  // SPI words carried by one FIFO word
  function automatic logic [LEN_W-1:0] wordsPerSlot(input logic [LEN_W-1:0] len);
    if (len == '0) return LEN_W'(1);
    if ((LEN_W'(FIFO_W) % len) == '0) return LEN_W'(FIFO_W) / len;
    return LEN_W'(1);
  endfunction
endpackage

// File: rtl/spi_pack_fifo.sv
module spi_pack_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [W-1:0]     pushData,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             wrErr,
  output logic             rdErr
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             isFull, isEmpty, doPush, doPop;

  assign isFull  = (count == CNT_W'(DEPTH));
  assign isEmpty = (count == '0);
  assign doPush  = push && !isFull;
  assign doPop   = pop && !isEmpty;
  assign head    = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      wrErr <= 1'b0;
      rdErr <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + PTR_W'(1);
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + PTR_W'(1);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
      if (push && isFull)  wrErr <= 1'b1;
      if (pop && isEmpty) rdErr <= 1'b1;
    end
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (push && isFull && !pop) |=> (count == $past(count)) && wrErr);
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pop && isEmpty && !push) |=> (count == '0) && rdErr);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrErr || rdErr) |=> ($stable(wrErr) || wrErr) && ($stable(rdErr) || rdErr));
endmodule

// File: rtl/spi_pack_ctrl.sv
module spi_pack_ctrl
  import spi_pack_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] cfgWordLen,
  input  logic             txHave,
  input  logic             txTake,
  input  logic             txEnd,
  input  logic             rxValid,
  input  logic             rxEnd,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             rxPop,
  output ctrl_t            ctrl,
  output logic             txPop,
  output logic             rxPush,
  output logic             rxLast,
  output logic [1:0]       rxLastBytes
);
  logic [LEN_W-1:0]   perWord, txSlot, rxFill, rxFillNext;
  logic [2*LEN_W-1:0] txProd, rxProd, rxBits, rxBytes;
  logic               txLastSlot, rxFull;

  assign perWord    = wordsPerSlot(cfgWordLen);
  assign txLastSlot = (txSlot + LEN_W'(1)) == perWord;
  assign txPop      = txHave && ((txTake && txLastSlot) || (txEnd && (txTake || txSlot != '0)));

  assign rxFillNext = rxFill + LEN_W'(rxValid);
  assign rxFull     = rxValid && (rxFillNext == perWord);
  assign rxPush     = rxFull || (rxEnd && rxFillNext != '0);

  assign txProd  = txSlot * cfgWordLen;
  assign rxProd  = rxFill * cfgWordLen;
  assign rxBits  = rxFillNext * cfgWordLen;
  assign rxBytes = (rxBits + (2*LEN_W)'(7)) >> 3;

  always_comb begin
    ctrl.rxMerge = rxValid;
    ctrl.rxClear = rxPush;
    ctrl.rxShift = rxProd[LEN_W-1:0];
    ctrl.txShift = txProd[LEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSlot      <= '0;
      rxFill      <= '0;
      rxLast      <= 1'b0;
      rxLastBytes <= '0;
    end else begin
      if (txPop) txSlot <= '0;
      else if (txHave && txTake) txSlot <= txSlot + LEN_W'(1);
      rxFill <= rxPush ? '0 : rxFillNext;
      if (rxEnd) begin
        rxLast      <= 1'b1;
        rxLastBytes <= rxBytes[1:0];
      end else if (rxPop && rxCount == CNT_W'(1) && !rxPush) begin
        rxLast <= 1'b0;
      end
    end
  end

  assert_slot_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    txSlot < perWord);
  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    rxFill < perWord);
  assert_last_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxEnd |=> rxLast);
endmodule

// File: rtl/spi_pack_dp.sv
module spi_pack_dp
  import spi_pack_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEN_W-1:0]  cfgWordLen,
  input  logic              cfgLsbFirst,
  input  ctrl_t             ctrl,
  input  logic [FIFO_W-1:0] txHead,
  input  logic [FIFO_W-1:0] rxWordIn,
  output logic [FIFO_W-1:0] txWordOut,
  output logic [FIFO_W-1:0] rxPushData
);
  logic [FIFO_W-1:0] accum, rxOriented, merged;

  assign rxOriented = orientWord(rxWordIn, cfgWordLen, cfgLsbFirst);
  assign merged     = accum | (rxOriented << ctrl.rxShift);
  assign rxPushData = ctrl.rxMerge ? merged : accum;
  assign txWordOut  = orientWord(txHead >> ctrl.txShift, cfgWordLen, cfgLsbFirst);

  always_ff @(posedge clk) begin
    if (!rstN)             accum <= '0;
    else if (ctrl.rxClear) accum <= '0;
    else if (ctrl.rxMerge) accum <= merged;
  end

  assert_accum_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.rxClear |=> accum == '0);
endmodule

// File: rtl/spi_pack_top.sv
module spi_pack_top
  import spi_pack_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEN_W-1:0]  cfgWordLen,
  input  logic              cfgLsbFirst,
  input  logic              hostTxPush,
  input  logic [FIFO_W-1:0] hostTxData,
  output logic              engTxValid,
  output logic [FIFO_W-1:0] engTxWord,
  input  logic              engTxTake,
  input  logic              engTxEnd,
  input  logic              engRxValid,
  input  logic [FIFO_W-1:0] engRxWord,
  input  logic              engRxEnd,
  output logic              engRxRoom,
  input  logic              hostRxPop,
  output logic [FIFO_W-1:0] hostRxData,
  output logic [CNT_W-1:0]  rxWordCount,
  output logic              rxLast,
  output logic [1:0]        rxLastBytes,
  output logic              errWr,
  output logic              errRd
);
  ctrl_t             ctrl;
  logic              txPop, rxPush;
  logic [FIFO_W-1:0] txHead, rxPushData;
  logic [CNT_W-1:0]  txCount;
  logic              txWrErr, txRdErr, rxWrErr, rxRdErr;

  assign engTxValid = (txCount != '0);
  assign engRxRoom  = (rxWordCount < CNT_W'(DEPTH - 2));
  assign errWr      = txWrErr | rxWrErr;
  assign errRd      = txRdErr | rxRdErr;

  spi_pack_fifo #(.W(FIFO_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_txFifo (
    .clk(clk), .rstN(rstN), .push(hostTxPush), .pushData(hostTxData),
    .pop(txPop), .head(txHead), .count(txCount), .wrErr(txWrErr), .rdErr(txRdErr));

  spi_pack_fifo #(.W(FIFO_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxFifo (
    .clk(clk), .rstN(rstN), .push(rxPush), .pushData(rxPushData),
    .pop(hostRxPop), .head(hostRxData), .count(rxWordCount), .wrErr(rxWrErr), .rdErr(rxRdErr));

  spi_pack_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWordLen(cfgWordLen),
    .txHave(engTxValid), .txTake(engTxTake), .txEnd(engTxEnd),
    .rxValid(engRxValid), .rxEnd(engRxEnd), .rxCount(rxWordCount), .rxPop(hostRxPop),
    .ctrl(ctrl), .txPop(txPop), .rxPush(rxPush), .rxLast(rxLast), .rxLastBytes(rxLastBytes));

  spi_pack_dp u_dp (
    .clk(clk), .rstN(rstN), .cfgWordLen(cfgWordLen), .cfgLsbFirst(cfgLsbFirst),
    .ctrl(ctrl), .txHead(txHead), .rxWordIn(engRxWord),
    .txWordOut(engTxWord), .rxPushData(rxPushData));
endmodule

// File: tb/spi_pack_top_tb.sv
module spi_pack_top_tb;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  cfgWordLen = 6'd8;
  logic        cfgLsbFirst = 1'b0;
  logic        hostTxPush = 1'b0;
  logic [31:0] hostTxData = '0;
  logic        engTxValid;
  logic [31:0] engTxWord;
  logic        engTxTake = 1'b0, engTxEnd = 1'b0;
  logic        engRxValid = 1'b0, engRxEnd = 1'b0;
  logic [31:0] engRxWord = '0;
  logic        engRxRoom;
  logic        hostRxPop = 1'b0;
  logic [31:0] hostRxData;
  logic [3:0]  rxWordCount;
  logic        rxLast;
  logic [1:0]  rxLastBytes;
  logic        errWr, errRd;

  int checks = 0;
  int errors = 0;
  logic [31:0] expTx[$];
  logic [31:0] expRx[$];
  string       txTag = "R1";
  string       rxTag = "R1";
  logic [31:0] modelAcc = '0;
  int          modelFill = 0;

  always #10 clk = ~clk;

  spi_pack_top #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int perWord(input int len);
    return (32 % len == 0) ? 32 / len : 1;
  endfunction

  function automatic logic [31:0] shapeWord(input logic [31:0] w, input int len, input logic lsb);
    logic [31:0] f = '0;
    for (int i = 0; i < len; i++) f[lsb ? (len - 1 - i) : i] = w[i];
    return f;
  endfunction

  // monitor: compares outputs against the scoreboard queues
  always @(negedge clk) begin
    if (rstN && engTxTake && engTxValid && expTx.size() > 0)
      check({txTag, " tx word"}, engTxWord, expTx.pop_front());
    if (rstN && hostRxPop && expRx.size() > 0)
      check({rxTag, " rx word"}, hostRxData, expRx.pop_front());
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic txLoad(input logic [31:0] d);
    hostTxPush = 1'b1; hostTxData = d; tick(); hostTxPush = 1'b0;
  endtask

  task automatic txRun(input logic [31:0] f, input int n, input logic endLast);
    int len = int'(cfgWordLen);
    for (int k = 0; k < n; k++) begin
      int waitCnt = 0;
      while (!engTxValid && waitCnt < 50) begin tick(); waitCnt++; end
      if (!engTxValid) begin
        errors++; checks++;
        $display("FAIL %s tx word missing actual=0 expected=1", txTag);
      end
      expTx.push_back(shapeWord(f >> (k * len), len, cfgLsbFirst));
      engTxTake = 1'b1; engTxEnd = endLast && (k == n - 1);
      tick();
      engTxTake = 1'b0; engTxEnd = 1'b0;
    end
  endtask

  task automatic rxSend(input logic [31:0] w, input logic endIt);
    int len = int'(cfgWordLen);
    modelAcc |= shapeWord(w, len, cfgLsbFirst) << (modelFill * len);
    modelFill++;
    if (modelFill == perWord(len) || endIt) begin
      expRx.push_back(modelAcc); modelAcc = '0; modelFill = 0;
    end
    engRxValid = 1'b1; engRxWord = w; engRxEnd = endIt;
    tick();
    engRxValid = 1'b0; engRxEnd = 1'b0;
  endtask

  task automatic rxPopOne();
    hostRxPop = 1'b1; tick(); hostRxPop = 1'b0;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    tick();
    // R9 reset state
    check("R9 txValid", 32'(engTxValid), 0);
    check("R9 rxCount", 32'(rxWordCount), 0);
    check("R9 rxLast", 32'(rxLast), 0);
    check("R9 errors", {errWr, errRd}, 0);
    check("R9 room", 32'(engRxRoom), 1);

    // R1 packed bytes, slot order
    txTag = "R1";
    txLoad(32'h44332211); txLoad(32'h88776655);
    txRun(32'h44332211, 4, 1'b0);
    txRun(32'h88776655, 4, 1'b0);
    check("R10 txValid drained", 32'(engTxValid), 0);

    // R3 mirrored nibbles
    txTag = "R3"; cfgWordLen = 6'd4; cfgLsbFirst = 1'b1;
    txLoad(32'h12345678);
    txRun(32'h12345678, 8, 1'b0);

    // R2 unpacked lengths
    txTag = "R2"; cfgWordLen = 6'd12; cfgLsbFirst = 1'b0;
    txLoad(32'hFFFFFABC);
    txRun(32'hFFFFFABC, 1, 1'b0);
    cfgWordLen = 6'd24; cfgLsbFirst = 1'b1;
    txLoad(32'hAB123456);
    txRun(32'hAB123456, 1, 1'b0);

    // R7 end drops remaining slots
    txTag = "R7"; cfgWordLen = 6'd8; cfgLsbFirst = 1'b0;
    txLoad(32'hDDCCBBAA); txLoad(32'h00000077);
    txRun(32'hDDCCBBAA, 2, 1'b1);
    txRun(32'h00000077, 1, 1'b1);
    check("R7 txValid after drop", 32'(engTxValid), 0);

    // R1/R4/R5/R6 receive packing with partial flush
    rxTag = "R1";
    rxSend(32'h11, 1'b0); rxSend(32'h22, 1'b0); rxSend(32'h33, 1'b0); rxSend(32'h44, 1'b0);
    check("R6 count one", 32'(rxWordCount), 1);
    rxTag = "R4";
    rxSend(32'h55, 1'b0); rxSend(32'h66, 1'b1);
    check("R6 count two", 32'(rxWordCount), 2);
    check("R5 last set", 32'(rxLast), 1);
    check("R4 bytes two", 32'(rxLastBytes), 2);
    rxPopOne();
    check("R5 last held", 32'(rxLast), 1);
    rxPopOne();
    check("R5 last cleared", 32'(rxLast), 0);
    check("R6 count zero", 32'(rxWordCount), 0);

    // R3 mirrored receive nibbles, partial
    rxTag = "R3"; cfgWordLen = 6'd4; cfgLsbFirst = 1'b1;
    rxSend(32'h1, 1'b0); rxSend(32'h2, 1'b0); rxSend(32'h3, 1'b1);
    check("R4 bytes nibble", 32'(rxLastBytes), 2);
    rxPopOne();

    // R2 unpacked receive, high bits cleared
    rxTag = "R2"; cfgWordLen = 6'd12; cfgLsbFirst = 1'b0;
    rxSend(32'hFFFFFABC, 1'b1);
    check("R4 bytes twelve", 32'(rxLastBytes), 2);
    rxPopOne();
    cfgWordLen = 6'd24;
    rxSend(32'h77123456, 1'b1);
    check("R4 bytes three", 32'(rxLastBytes), 3);
    rxPopOne();

    // R4 end on a full word reports all bytes
    rxTag = "R4"; cfgWordLen = 6'd8;
    rxSend(32'hA1, 1'b0); rxSend(32'hA2, 1'b0); rxSend(32'hA3, 1'b0); rxSend(32'hA4, 1'b1);
    check("R4 bytes full", 32'(rxLastBytes), 0);
    check("R4 count full", 32'(rxWordCount), 1);
    rxPopOne();

    // R6 ready level
    rxTag = "R6"; cfgWordLen = 6'd32;
    for (int i = 0; i < 5; i++) rxSend(32'hBEEF0000 + 32'(i), 1'b0);
    check("R6 room at five", 32'(engRxRoom), 1);
    rxSend(32'hBEEF0005, 1'b0);
    check("R6 room at six", 32'(engRxRoom), 0);
    check("R6 count six", 32'(rxWordCount), 6);
    for (int i = 0; i < 6; i++) rxPopOne();

    // R8 underflow
    check("R8 no write error yet", 32'(errWr), 0);
    rxPopOne();
    check("R8 read error", 32'(errRd), 1);
    check("R8 count after underflow", 32'(rxWordCount), 0);

    // R8 overflow: ninth word dropped
    txTag = "R8";
    for (int i = 0; i < 9; i++) txLoad(32'hC0DE0000 + 32'(i));
    check("R8 write error", 32'(errWr), 1);
    for (int i = 0; i < 8; i++) txRun(32'hC0DE0000 + 32'(i), 1, 1'b0);
    check("R8 ninth dropped", 32'(engTxValid), 0);
    check("R8 tx queue used", 32'(expTx.size()), 0);
    check("R8 rx queue used", 32'(expRx.size()), 0);

    finishRun();
  end
endmodule